// File: doc/BRIEF.md
# Segmented Charge Pump Switch Controller

This block is the digital core of a switched-capacitor step-down converter. It produces two non-overlapping drive phases separated by a programmable dead time. It maps those phases onto four power switches, either as a halving (2:1) arrangement or as a pass-through (1:1) arrangement. Every switch is built from three separately gated segments: a first quarter, a second quarter and a half.

Regulation works by pulse skipping. When the output passes its upper threshold, all switching stops. Switching starts again when the output falls below its lower threshold. Each restart uses only the first quarter segment. If regulation is still not reached, the controller widens the switches one step at a time, counting completed charge cycles. A startup flag forces full width.

The analog comparators, the oscillator and the drivers sit outside the block. They reach it as synchronous digital inputs.

Top module: `scp_ctrl`

## Requirements
- R1: Switch bits are indexed 0..3 for switches 1..4. In 2:1 mode, phase A drives switches 1 and 3, phase B drives switches 2 and 4, and switches 1 and 2 are never on together.
- R2: In 1:1 mode, while switching, switch 3 stays off and switch 4 stays on in every cycle. Switch 1 follows phase A and switch 2 follows phase B.
- R3: Between the end of one phase and the start of the other, in both directions, every phase output is off for exactly max(1, `dead_cfg`) clocks. Each phase lasts `PH_LEN` clocks.
- R4: In the cycle after a clock edge that samples `above_hi` high, all segment outputs are zero. They stay zero until `below_lo` is sampled high.
- R5: Switching that resumes after a skip, or that begins after reset or enable, uses only the first quarter segment (`seg_qa`). The count of charge cycles restarts from zero.
- R6: After `Q2H_CYC` (default 3) completed charge cycles at quarter width without reaching the upper threshold, the second quarter segment (`seg_qb`) turns on as well. A charge cycle is one phase A followed by one phase B.
- R7: After `H2F_CYC` (default 7) further completed cycles at half width, the half segment (`seg_hf`) turns on as well.
- R8: While `startup` is high, every active switch drives all three segments, whatever the cycle count.
- R9: `mode_half` (1 selects 2:1, 0 selects 1:1) is sampled only at the clock edge that starts phase A. A change during a phase or during dead time does not alter the mapping until that edge.
- R10: A low `en` turns every segment off from the next cycle. It restores the start-up state: switching at quarter width in 2:1 mapping.
- R11: When `above_hi` and `below_lo` are both high, `above_hi` wins and the block stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low forces everything off |
| startup | input | 1 | Forces full-width switching |
| mode_half | input | 1 | 1 = 2:1 mapping, 0 = 1:1 mapping |
| above_hi | input | 1 | Output above upper threshold |
| below_lo | input | 1 | Output below lower threshold |
| dead_cfg | input | DEAD_W | Dead time in clocks (0 treated as 1) |
| seg_qa | output | 4 | First quarter segment enable, one bit per switch |
| seg_qb | output | 4 | Second quarter segment enable, one bit per switch |
| seg_hf | output | 4 | Half segment enable, one bit per switch |

## Verification
The assertions check the following on every cycle:
- Switches 1 and 2 never conduct together.
- A phase never starts in the clock right after the other phase ends.
- Everything goes dark one cycle after the upper threshold is seen, or after enable drops.
- The latched mode changes only at the start of phase A.
- Width never shrinks while switching continues.
- Startup forces all segments on.

Some behaviour can only be shown by the directed scenarios, because each needs a sequence of events:
- The exact width step points at cycles 3 and 10.
- The dead-time lengths for several settings.
- The quarter-width restart after a skip or after enable.
- The held mapping across a mode change made during phase B.

// File: rtl/scp_pkg.sv
// Shared types for the segmented charge pump controller.
package scp_pkg;
    // Phase generator states
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_DBA  = 3'd1,
        PH_A    = 3'd2,
        PH_DAB  = 3'd3,
        PH_B    = 3'd4
    } phase_e;

    // Active switch width, ordered so that a wider setting compares larger
    typedef enum logic [1:0] {
        W_QTR  = 2'd0,
        W_HALF = 2'd1,
        W_FULL = 2'd2
    } width_e;

    localparam int unsigned NSW = 4;
endpackage

// File: rtl/scp_phase_gen.sv
// Two-phase non-overlapping generator.
// Runs while run is high: dead, A, dead, B, repeating. Each phase lasts PH_LEN
// clocks and each dead gap lasts max(1, dead_cfg) clocks.
// Assumes run and en are synchronous. Drops to idle the clock after run falls.
module scp_phase_gen
    import scp_pkg::*;
#(
    parameter int PH_LEN = 4,
    parameter int DW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          run,
    input  logic [DW-1:0] dead_cfg,
    output logic          ph_a,
    output logic          ph_b,
    output logic          a_start,
    output logic          cyc_done
);
    localparam int PLW = $clog2(PH_LEN + 1);
    localparam int TW  = (DW > PLW) ? DW : PLW;

    phase_e          state;
    logic [TW-1:0]   tmr;
    logic [DW-1:0]   dead_m1;
    logic [TW-1:0]   ph_m1;

    // Dead time minus one, with zero clamped to a one-clock gap
    always_comb dead_m1 = (dead_cfg == '0) ? '0 : dead_cfg - 1'b1;
    always_comb ph_m1   = TW'(PH_LEN - 1);

    // State and timer sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !run) begin
            state <= PH_IDLE;
            tmr   <= '0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    state <= PH_DBA;
                    tmr   <= TW'(dead_m1);
                end
                PH_DBA: begin
                    if (tmr == '0) begin
                        state <= PH_A;
                        tmr   <= ph_m1;
                    end else tmr <= tmr - 1'b1;
                end
                PH_A: begin
                    if (tmr == '0) begin
                        state <= PH_DAB;
                        tmr   <= TW'(dead_m1);
                    end else tmr <= tmr - 1'b1;
                end
                PH_DAB: begin
                    if (tmr == '0) begin
                        state <= PH_B;
                        tmr   <= ph_m1;
                    end else tmr <= tmr - 1'b1;
                end
                PH_B: begin
                    if (tmr == '0) begin
                        state <= PH_DBA;
                        tmr   <= TW'(dead_m1);
                    end else tmr <= tmr - 1'b1;
                end
                default: begin
                    state <= PH_IDLE;
                    tmr   <= '0;
                end
            endcase
        end
    end

    // Phase outputs and boundary strobes
    always_comb begin
        ph_a     = (state == PH_A);
        ph_b     = (state == PH_B);
        a_start  = run && (state == PH_DBA) && (tmr == '0);
        cyc_done = run && (state == PH_B) && (tmr == '0);
    end

    AST_GAP_BEFORE_B: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_b) |-> !$past(ph_a)); // R3
    AST_GAP_BEFORE_A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_a) |-> !$past(ph_b)); // R3
endmodule

// File: rtl/scp_width_ctrl.sv
// Skip hysteresis and switch-width stepping.
// Stops on above_hi and resumes on below_lo (above_hi wins). On every resume,
// restarts at quarter width with the cycle count cleared. Steps to half width
// after Q2H_CYC charge cycles and to full width after a further H2F_CYC.
// Assumes cyc_done pulses once per completed A+B pair.
module scp_width_ctrl
    import scp_pkg::*;
#(
    parameter int Q2H_CYC = 3,
    parameter int H2F_CYC = 7
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   startup,
    input  logic   above_hi,
    input  logic   below_lo,
    input  logic   cyc_done,
    output logic   run,
    output width_e width
);
    localparam int CMAX = (Q2H_CYC > H2F_CYC) ? Q2H_CYC : H2F_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    logic          run_q;
    width_e        wid_q;
    logic [CW-1:0] cnt;

    // Run/skip state, width level and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q <= 1'b1;
            wid_q <= W_QTR;
            cnt   <= '0;
        end else if (run_q) begin
            if (above_hi) begin
                run_q <= 1'b0;
            end else if (cyc_done) begin
                unique case (wid_q)
                    W_QTR: begin
                        if (cnt == CW'(Q2H_CYC - 1)) begin
                            wid_q <= W_HALF;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    W_HALF: begin
                        if (cnt == CW'(H2F_CYC - 1)) begin
                            wid_q <= W_FULL;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: cnt <= '0;
                endcase
            end
        end else if (below_lo && !above_hi) begin
            run_q <= 1'b1;
            wid_q <= W_QTR;
            cnt   <= '0;
        end
    end

    // Effective width: startup overrides the stepped level
    always_comb begin
        run   = run_q;
        width = startup ? W_FULL : wid_q;
    end

    AST_WIDTH_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && run_q && $past(run_q) |-> wid_q >= $past(wid_q)); // R6
    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en && !run_q && !below_lo |=> !run_q); // R4
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        en && above_hi |=> !run_q); // R11
endmodule

// File: rtl/scp_seg_map.sv
// Maps the phases onto four switches and three segments per switch.
// The 2:1 mapping uses A for switches 1 and 3 and B for switches 2 and 4.
// The 1:1 mapping keeps switch 4 on and switch 3 off. The width selects
// which segments follow. Purely combinational.
module scp_seg_map
    import scp_pkg::*;
(
    input  logic           active,
    input  logic           mode_21,
    input  logic           ph_a,
    input  logic           ph_b,
    input  width_e         width,
    output logic [NSW-1:0] seg_qa,
    output logic [NSW-1:0] seg_qb,
    output logic [NSW-1:0] seg_hf
);
    logic [NSW-1:0] on;
    logic           use_qb;
    logic           use_hf;

    // Per-switch conduct request from mode and phase
    always_comb begin
        if (!active)      on = '0;
        else if (mode_21) on = {ph_b, ph_a, ph_b, ph_a};
        else              on = {1'b1, 1'b0, ph_b, ph_a};
        use_qb = (width != W_QTR);
        use_hf = (width == W_FULL);
    end

    for (genvar s = 0; s < NSW; s++) begin : g_sw
        assign seg_qa[s] = on[s];
        assign seg_qb[s] = on[s] & use_qb;
        assign seg_hf[s] = on[s] & use_hf;
    end
endmodule

// File: rtl/scp_ctrl.sv
// Top of the segmented charge pump switch controller.
// Ties together the phase generator, the skip/width logic and the segment
// map, and latches the mode at each start of phase A.
// Assumes every comparator input is already synchronous to clk.
module scp_ctrl
    import scp_pkg::*;
#(
    parameter int PH_LEN  = 4,
    parameter int DEAD_W  = 4,
    parameter int Q2H_CYC = 3,
    parameter int H2F_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              startup,
    input  logic              mode_half,
    input  logic              above_hi,
    input  logic              below_lo,
    input  logic [DEAD_W-1:0] dead_cfg,
    output logic [3:0]        seg_qa,
    output logic [3:0]        seg_qb,
    output logic [3:0]        seg_hf
);
    logic   run;
    logic   ph_a;
    logic   ph_b;
    logic   a_start;
    logic   cyc_done;
    logic   mode_q;
    width_e width;

    scp_width_ctrl #(.Q2H_CYC(Q2H_CYC), .H2F_CYC(H2F_CYC)) u_width (
        .clk(clk), .rst_n(rst_n), .en(en), .startup(startup),
        .above_hi(above_hi), .below_lo(below_lo), .cyc_done(cyc_done),
        .run(run), .width(width)
    );

    scp_phase_gen #(.PH_LEN(PH_LEN), .DW(DEAD_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en), .run(run), .dead_cfg(dead_cfg),
        .ph_a(ph_a), .ph_b(ph_b), .a_start(a_start), .cyc_done(cyc_done)
    );

    // Mode latch, updated only at the edge that starts phase A
    always_ff @(posedge clk) begin
        if (!rst_n || !en) mode_q <= 1'b1;
        else if (a_start)  mode_q <= mode_half;
    end

    scp_seg_map u_map (
        .active(run && en), .mode_21(mode_q), .ph_a(ph_a), .ph_b(ph_b),
        .width(width), .seg_qa(seg_qa), .seg_qb(seg_qb), .seg_hf(seg_hf)
    );

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_qa[0] && seg_qa[1])); // R1
    AST_ONE_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        en && run && !mode_q |-> !seg_qa[2] && seg_qa[3]); // R2
    AST_SKIP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        en && above_hi |=> (seg_qa == '0) && (seg_qb == '0) && (seg_hf == '0)); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en && !a_start |=> $stable(mode_q)); // R9
    AST_EN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (seg_qa == '0) && (seg_qb == '0) && (seg_hf == '0)); // R10
    AST_STARTUP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        startup |-> (seg_hf == seg_qa) && (seg_qb == seg_qa)); // R8
endmodule

// File: tb/tb_scp_ctrl.sv
module tb_scp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PH_LEN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic startup = 1'b0;
    logic mode_half = 1'b1;
    logic above_hi = 1'b0;
    logic below_lo = 1'b0;
    logic [3:0] dead_cfg = 4'd1;
    logic [3:0] seg_qa;
    logic [3:0] seg_qb;
    logic [3:0] seg_hf;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en(en), .startup(startup),
        .mode_half(mode_half), .above_hi(above_hi), .below_lo(below_lo),
        .dead_cfg(dead_cfg), .seg_qa(seg_qa), .seg_qb(seg_qb), .seg_hf(seg_hf)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit dark();
        return (seg_qa == 4'd0) && (seg_qb == 4'd0) && (seg_hf == 4'd0);
    endfunction

    // Waits for switch 1 to turn on; returns its {half, q2, q1} segments
    task automatic wait_a_rise(output logic [2:0] w);
        int n = 0;
        while (seg_qa[0] === 1'b1 && n < 400) begin tick(); n++; end
        while (seg_qa[0] !== 1'b1 && n < 400) begin tick(); n++; end
        if (n >= 400) chk(1'b0, "timeout waiting for phase A", n, 0);
        w = {seg_hf[0], seg_qb[0], seg_qa[0]};
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(dark(), "R10 outputs off right after reset", int'(seg_qa), 0);
    endtask

    task automatic t_stepping();
        logic [2:0] w;
        for (int i = 1; i <= 11; i++) begin
            int e;
            wait_a_rise(w);
            e = (i <= 3) ? 1 : (i <= 10) ? 3 : 7;
            chk(w == 3'(e), $sformatf("R5/R6/R7 width at cycle %0d", i), int'(w), e);
            chk(seg_qa == 4'b0101, "R1 phase A drives switches 1 and 3", int'(seg_qa), 5);
        end
    endtask

    task automatic t_dead(input int d);
        logic [2:0] w;
        int exp = (d == 0) ? 1 : d;
        int ab = 0;
        int ba = 0;
        int alen = 0;
        dead_cfg = 4'(d);
        wait_a_rise(w);
        wait_a_rise(w);
        while (seg_qa[0] && alen < 50) begin alen++; tick(); end
        while (!seg_qa[1] && ab < 50) begin ab++; tick(); end
        chk(seg_qa[3] == 1'b1, "R1 phase B drives switch 4", int'(seg_qa[3]), 1);
        while (seg_qa[1]) tick();
        while (!seg_qa[0] && ba < 50) begin ba++; tick(); end
        chk(alen == PH_LEN, "R3 phase A length", alen, PH_LEN);
        chk(ab == exp, $sformatf("R3 gap A->B dead=%0d", d), ab, exp);
        chk(ba == exp, $sformatf("R3 gap B->A dead=%0d", d), ba, exp);
    endtask

    task automatic t_skip();
        logic [2:0] w;
        bit ok = 1'b1;
        above_hi = 1'b1;
        tick();
        chk(dark(), "R4 off one cycle after upper threshold", int'(seg_qa), 0);
        above_hi = 1'b0;
        for (int i = 0; i < 20; i++) begin tick(); if (!dark()) ok = 1'b0; end
        chk(ok, "R4 stays off while skipping", int'(ok), 1);
        below_lo = 1'b1;
        tick();
        below_lo = 1'b0;
        wait_a_rise(w);
        chk(w == 3'b001, "R5 resume at quarter width", int'(w), 1);
    endtask

    task automatic t_both_flags();
        bit ok = 1'b1;
        above_hi = 1'b1;
        tick();
        below_lo = 1'b1;
        for (int i = 0; i < 6; i++) begin tick(); if (!dark()) ok = 1'b0; end
        above_hi = 1'b0;
        below_lo = 1'b0;
        tick();
        chk(ok && dark(), "R11 upper threshold wins over lower", int'(ok), 1);
    endtask

    task automatic t_startup();
        logic [2:0] w;
        startup = 1'b1;
        below_lo = 1'b1;
        tick();
        below_lo = 1'b0;
        wait_a_rise(w);
        chk(w == 3'b111, "R8 startup forces full width", int'(w), 7);
        startup = 1'b0;
        wait_a_rise(w);
        chk(w == 3'b001, "R8 stepped width after startup clears", int'(w), 1);
    endtask

    task automatic t_one_to_one();
        logic [2:0] w;
        bit ok = 1'b1;
        int na = 0;
        int nb = 0;
        mode_half = 1'b0;
        wait_a_rise(w);
        wait_a_rise(w);
        for (int i = 0; i < 40; i++) begin
            if (seg_qa[2] || !seg_qa[3]) ok = 1'b0;
            if (seg_qa[0]) na++;
            if (seg_qa[1]) nb++;
            tick();
        end
        chk(ok, "R2 switch 3 off and switch 4 on", int'(seg_qa), 8);
        chk(na > 0 && nb > 0, "R2 switches 1 and 2 still alternate", na * nb, 1);
    endtask

    task automatic t_mode_boundary();
        logic [2:0] w;
        int n = 0;
        while (!seg_qa[1] && n < 100) begin tick(); n++; end
        mode_half = 1'b1;
        while (seg_qa[1] && n < 200) begin tick(); n++; end
        chk(seg_qa[3] == 1'b1 && seg_qa[2] == 1'b0,
            "R9 mapping held through dead time", int'(seg_qa), 8);
        wait_a_rise(w);
        chk(seg_qa == 4'b0101, "R9 new mapping from start of phase A", int'(seg_qa), 5);
    endtask

    task automatic t_enable();
        logic [2:0] w;
        for (int i = 0; i < 12; i++) wait_a_rise(w);
        chk(w == 3'b111, "R7 full width reached before disable", int'(w), 7);
        en = 1'b0;
        tick();
        chk(dark(), "R10 off after enable drops", int'(seg_qa), 0);
        repeat (3) tick();
        en = 1'b1;
        wait_a_rise(w);
        chk(w == 3'b001 && seg_qa == 4'b0101,
            "R10 restart at quarter width in 2:1", int'({seg_qa, w}), 41);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_stepping();
        t_dead(3);
        t_dead(0);
        t_dead(2);
        dead_cfg = 4'd1;
        t_skip();
        t_both_flags();
        t_startup();
        t_one_to_one();
        t_mode_boundary();
        t_enable();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule